// File: doc/BRIEF.md
# CAN Message Buffer Page Window

This block gives a host processor byte access to the data buffers of the message objects in a CAN controller. Each of the six message objects owns an 8-byte data buffer, and all six buffers sit in a 48-byte data RAM inside the block. The host sees two byte-wide registers on a simple register bus. The first is a page register. It selects the object, the byte position inside that object's buffer, and whether the byte position steps on its own. The second is a data port. It reads or writes the byte that the page register selects.

The usual host sequence loads the page register once and then streams up to eight bytes through the data port. The byte index advances after every data-port access and wraps within the buffer. Setting the hold bit keeps the index fixed, so one byte can be polled or rewritten repeatedly. Object numbers above the valid range give a safe empty window: writes are dropped and reads return zero.

Top module: `can_msgbuf_window`

## Requirements
- R1: After a synchronous active-low reset, the page register reads 0x00. This means object 0, byte index 0, and stepping enabled.
- R2: The page register layout is object number in bits 7:4, hold bit in bit 3 and byte index in bits 2:0. Bit 7 always reads 0, even after a write of 1.
- R3: A data-port write to a valid object stores the byte at that object's selected index. A later data-port read at the same object and index returns it.
- R4: While the hold bit is 0, each data-port read or write advances the byte index by one in the following cycle.
- R5: The byte index wraps from 7 to 0 when it steps.
- R6: While the hold bit is 1, data-port reads and writes leave the byte index unchanged.
- R7: For object numbers 6 and 7, data-port writes change no RAM byte and data-port reads return 0x00. The index still steps.
- R8: A page-register write loads the byte index directly, with no step in that cycle.
- R9: The buffers of different objects are independent: a write to one object leaves the bytes of every other object unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 selects the page register, 1 selects the data port |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_rd | input | 1 | Read strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data. It is combinational while bus_rd is high and 0 otherwise |

## Verification
A wrong page-register state shows up on the first page read after the fault. It also shows up on the next data read, because that read returns the byte at a different buffer position. A missed or extra index step misplaces every byte that follows in a streamed transfer. For that reason, write bursts are read back in order, and across the 7-to-0 wrap. A decode error on the object number appears either as a nonzero read from an invalid object or as a corrupted byte in another object's buffer. Those bytes are read back after the stray writes.

// File: rtl/can_msgbuf_pkg.sv
// Package: shared constants and the page register layout for the
// message buffer window. Assumes byte-wide buffers of eight entries.
package can_msgbuf_pkg;
    localparam int DATA_W    = 8;
    localparam int BUF_BYTES = 8;
    localparam int IDX_W     = $clog2(BUF_BYTES);
    localparam int OBJ_W     = 4;
    localparam int MAX_OBJ   = 6;

    // Page register: object number, hold (stepping disabled), byte index.
    typedef struct packed {
        logic [OBJ_W-1:0] obj;
        logic             hold;
        logic [IDX_W-1:0] idx;
    } page_t;

    localparam logic [OBJ_W-1:0] OBJ_MASK = {1'b0, {(OBJ_W-1){1'b1}}};
    localparam logic             SEL_PAGE = 1'b0;
    localparam logic             SEL_DATA = 1'b1;
endpackage

// File: rtl/can_msgbuf_page.sv
// Module: page register. It holds the object select, the hold bit and the
// byte index. A bus write loads all fields, with the top object bit
// forced to zero. Otherwise each data access steps the index unless hold
// is set. Assumes a page write and a data access never coincide.
module can_msgbuf_page
    import can_msgbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              data_acc,
    output page_t             page
);
    page_t loaded;

    // Decode the written byte into fields, masking the reserved object bit.
    always_comb begin
        loaded      = page_t'(wdata);
        loaded.obj  = wdata[DATA_W-1 -: OBJ_W] & OBJ_MASK;
    end

    // Register update: reset, direct load, or index step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page <= '0;
        end else if (page_wr) begin
            page <= loaded;
        end else if (data_acc && !page.hold) begin
            page.idx <= page.idx + 1'b1;
        end
    end
endmodule

// File: rtl/can_msgbuf_ram.sv
// Module: data RAM shared by all object buffers. It has a synchronous
// write and an asynchronous read. The contents are not reset.
module can_msgbuf_ram #(
    parameter int DEPTH = 48,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store one byte on a write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Present the addressed byte.
    assign rdata = mem[addr];
endmodule

// File: rtl/can_msgbuf_window.sv
// Module: host access window into the per-object data buffers.
// Address 0 is the page register and address 1 is the data port. The data
// port reaches byte (object * BUF_BYTES + index). Objects at or above
// NUM_OBJ are closed: writes are dropped and reads return zero.
// Assumes the host does not strobe read and write to different registers
// in the same cycle.
module can_msgbuf_window
    import can_msgbuf_pkg::*;
#(
    parameter int NUM_OBJ = MAX_OBJ,
    localparam int DEPTH  = NUM_OBJ * BUF_BYTES,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    page_t             page_q;
    logic              page_wr;
    logic              data_acc;
    logic              obj_ok;
    logic              ram_we;
    logic [AW-1:0]     ram_addr;
    logic [DATA_W-1:0] ram_rdata;

    // Bus decode and buffer address formation.
    always_comb begin
        page_wr  = bus_wr && (bus_addr == SEL_PAGE);
        data_acc = (bus_wr || bus_rd) && (bus_addr == SEL_DATA);
        obj_ok   = 32'(page_q.obj) < NUM_OBJ;
        ram_we   = bus_wr && (bus_addr == SEL_DATA) && obj_ok;
        ram_addr = AW'(32'(page_q.obj) * BUF_BYTES + 32'(page_q.idx));
    end

    can_msgbuf_page u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .page_wr  (page_wr),
        .wdata    (bus_wdata),
        .data_acc (data_acc),
        .page     (page_q)
    );

    can_msgbuf_ram #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (bus_wdata),
        .rdata (ram_rdata)
    );

    // Read mux: page register, buffer byte, or zero for a closed object.
    always_comb begin
        if (!bus_rd)                   bus_rdata = '0;
        else if (bus_addr == SEL_PAGE) bus_rdata = page_q;
        else if (obj_ok)               bus_rdata = ram_rdata;
        else                           bus_rdata = '0;
    end
endmodule

// File: rtl/can_msgbuf_window_chk.sv
// Module: property checker for the window. It watches the bus and the
// page register state.
module can_msgbuf_window_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic [7:0] page
);
    logic acc;
    logic pw;
    assign acc = (bus_wr || bus_rd) && bus_addr;
    assign pw  = bus_wr && !bus_addr;

    // R2: reserved object bit never set
    p_top_bit_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        page[7] == 1'b0);

    // R4 / R5: stepping index, wrapping modulo eight
    p_index_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !page[3]) |=> (page[2:0] == 3'($past(page[2:0]) + 3'd1)));

    // R6: hold bit freezes the page register
    p_index_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && page[3]) |=> $stable(page));

    // R7: closed objects read as zero
    p_closed_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr && (page[6:4] >= 3'd6)) |-> (bus_rdata == 8'h00));

    // R8: page write loads fields with no step
    p_page_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pw |=> (page == {1'b0, $past(bus_wdata[6:0])}));
endmodule

bind can_msgbuf_window can_msgbuf_window_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .page      (page_q)
);

// File: tb/can_msgbuf_window_bench.sv
module can_msgbuf_window_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    can_msgbuf_window u_can_msgbuf_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // Vector: {req[3:0], op[1:0], data[7:0], expected[7:0]}
    // op: 0 page write, 1 data write, 2 page read, 3 data read
    localparam int NV = 34;
    localparam logic [21:0] VEC [NV] = '{
        {4'd1, 2'd2, 8'h00, 8'h00},  // R1 reset value
        {4'd8, 2'd0, 8'h15, 8'h00},  // obj1 idx5
        {4'd8, 2'd2, 8'h00, 8'h15},  // R8 loaded, no step
        {4'd3, 2'd1, 8'hA0, 8'h00},  // R3 byte5
        {4'd3, 2'd1, 8'hA1, 8'h00},  // byte6
        {4'd5, 2'd1, 8'hA2, 8'h00},  // byte7 then wrap
        {4'd5, 2'd2, 8'h00, 8'h10},  // R5 index wrapped to 0
        {4'd2, 2'd0, 8'h95, 8'h00},  // top bit set on write
        {4'd2, 2'd2, 8'h00, 8'h15},  // R2 top bit reads 0
        {4'd3, 2'd3, 8'h00, 8'hA0},  // R3 readback
        {4'd3, 2'd3, 8'h00, 8'hA1},
        {4'd5, 2'd3, 8'h00, 8'hA2},
        {4'd4, 2'd2, 8'h00, 8'h10},  // R4 reads stepped and wrapped
        {4'd6, 2'd0, 8'h1D, 8'h00},  // hold, idx5
        {4'd6, 2'd3, 8'h00, 8'hA0},  // R6
        {4'd6, 2'd3, 8'h00, 8'hA0},
        {4'd6, 2'd2, 8'h00, 8'h1D},
        {4'd7, 2'd0, 8'h60, 8'h00},  // obj6
        {4'd7, 2'd1, 8'h55, 8'h00},
        {4'd7, 2'd3, 8'h00, 8'h00},  // R7 closed read
        {4'd7, 2'd2, 8'h00, 8'h62},  // R7 index still steps
        {4'd7, 2'd0, 8'h70, 8'h00},  // obj7
        {4'd7, 2'd3, 8'h00, 8'h00},
        {4'd9, 2'd0, 8'h20, 8'h00},  // obj2 idx0
        {4'd9, 2'd1, 8'h77, 8'h00},
        {4'd9, 2'd0, 8'h15, 8'h00},
        {4'd9, 2'd3, 8'h00, 8'hA0},  // R9 obj1 untouched
        {4'd9, 2'd0, 8'h20, 8'h00},
        {4'd9, 2'd3, 8'h00, 8'h77},  // R9 obj2 byte kept
        {4'd8, 2'd0, 8'h05, 8'h00},  // obj0 idx5
        {4'd8, 2'd1, 8'h3C, 8'h00},
        {4'd8, 2'd0, 8'h05, 8'h00},  // R8 reload index
        {4'd8, 2'd3, 8'h00, 8'h3C},
        {4'd8, 2'd2, 8'h00, 8'h06}
    };

    // Compare the read data against the expected value and count the result.
    task automatic check(input int req, input logic [7:0] exp);
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL R%0d: rdata=%02h expected=%02h", req, bus_rdata, exp);
        end
    endtask

    // Drive one bus operation for one cycle; reads are checked before the edge.
    task automatic bus_op(input int req, input logic [1:0] op,
                          input logic [7:0] d, input logic [7:0] exp);
        @(negedge clk);
        bus_addr  = op[0];
        bus_wr    = !op[1];
        bus_rd    = op[1];
        bus_wdata = d;
        if (op == 2'd2) bus_addr = 1'b0;
        if (op == 2'd0) bus_addr = 1'b0;
        if (op == 2'd1 || op == 2'd3) bus_addr = 1'b1;
        #1;
        if (op[1]) check(req, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            bus_op(int'(VEC[i][21:18]), VEC[i][17:16], VEC[i][15:8], VEC[i][7:0]);
        end
        // R1: reset mid-run clears the page register
        bus_op(1, 2'd0, 8'h3B, 8'h00);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_op(1, 2'd2, 8'h00, 8'h00);
        // R5 / R4: stream across the wrap on obj3 and read back in order
        bus_op(5, 2'd0, 8'h37, 8'h00);
        bus_op(5, 2'd1, 8'hC7, 8'h00);
        bus_op(5, 2'd1, 8'hC0, 8'h00);
        bus_op(5, 2'd0, 8'h37, 8'h00);
        bus_op(5, 2'd3, 8'h00, 8'hC7);
        bus_op(5, 2'd3, 8'h00, 8'hC0);
        bus_op(4, 2'd2, 8'h00, 8'h31);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R0: watchdog expired actual=hung expected=done");
        finish_run();
    end
endmodule